// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the timing and sequencing core of an eight-input successive-approximation converter. It divides the bus clock down to a conversion clock and times a two-part sample window for each conversion. It then runs a binary search, one trial per conversion clock, by driving a code to the DAC and reading back a single comparator bit. Across a sequence of one to eight conversions it steps the input multiplexer and hands each finished code out with a result-slot index.

A sequence begins in one of three ways. A start pulse aborts any work in progress, clears the slot index and begins again. A trigger pulse begins a sequence only when the block is idle, and it keeps the slot index. A configuration-write pulse aborts the work and clears the index without starting anything. In continuous mode, sequences follow one another with no gap. In FIFO mode, the slot index runs on across sequence boundaries. The configuration fields are plain inputs, and the surrounding register logic is expected to keep them still while a sequence runs. The analog front end, the register bus and the result storage sit outside this block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion clock period is D = 2*(prs+1) bus cycles. After a start or trigger is accepted at edge E, conversion m (counting from 0 across back-to-back sequences) ends with its strobe visible in the cycle after edge E + D*T*(m+1).
- R2: Each conversion takes T = 2 + S + B conversion clocks. The first sample part is 2 clocks. S is the second sample part, set by smp_sel: 0→2, 1→4, 2→8, 3→16. B is the number of bit trials.
- R3: len_code 1..7 gives that many conversions per sequence. len_code 0, or any value of 8 or more, gives 8. seq_done is high only with the strobe of the last conversion in a sequence.
- R4: With scan=0 the block goes idle after one sequence and busy falls. With scan=1 a new sequence starts at once from the base channel.
- R5: With multi=0 every conversion uses chan_sel. With multi=1, conversion k of a sequence uses (chan_sel+k) mod 8, so input 7 wraps to input 0.
- R6: With fifo=0, res_idx counts 0..L-1 in every sequence. With fifo=1 it continues across sequences and wraps from 7 to 0.
- R7: A cfg_wr pulse aborts the sequence: no further strobe follows, busy falls, and the next start places its first result in slot 0 even with fifo=1.
- R8: With res8=1 only 8 trials are run (B=8). The result occupies res_code[9:2], and res_code[1:0] is 0.
- R9: The bit trials run MSB first, one per conversion clock. A trial bit is kept when cmp_in is high and cleared when it is low. For an input that compares high exactly when its value is at least dac_code, res_code equals that value.
- R10: After reset, busy, res_vld, seq_done and dac_code are 0. res_vld and seq_done are high for exactly one bus cycle at a time.
- R11: While pwr_en is low the block is idle, start pulses are ignored, and a running sequence is aborted.
- R12: trig_start begins a sequence only when the block is idle, without clearing res_idx. A trigger during a running sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Enables the converter; low forces idle |
| start | input | 1 | Abort, clear slot index, begin a sequence |
| trig_start | input | 1 | Begin a sequence when idle, keep slot index |
| cfg_wr | input | 1 | Abort the sequence and clear the slot index |
| prs | input | 5 | Prescaler value; conversion clock = bus/(2*(prs+1)) |
| smp_sel | input | 2 | Second sample part length code |
| len_code | input | 4 | Conversions per sequence code |
| res8 | input | 1 | 1 = 8-bit conversion, 0 = 10-bit |
| multi | input | 1 | 1 = step the input each conversion |
| scan | input | 1 | 1 = continuous sequences |
| fifo | input | 1 | 1 = slot index runs across sequences |
| chan_sel | input | 3 | Base input channel |
| cmp_in | input | 1 | Comparator result for the current DAC code |
| mux_sel | output | 3 | Input multiplexer select |
| dac_code | output | 10 | Trial code to the DAC, 0 outside trials |
| res_vld | output | 1 | One-cycle strobe per finished conversion |
| res_idx | output | 3 | Result slot for the strobed code |
| res_code | output | 10 | Finished conversion code |
| seq_done | output | 1 | One-cycle pulse with the last strobe of a sequence |
| busy | output | 1 | A sequence is running |

## Verification
The bench uses an ideal comparator model over eight held input values. This lets every strobe be checked for its exact cycle, its slot and its code. A timing error in the prescaler or in either sample part shifts every strobe by whole conversion clocks. An off-by-one in the length decode, or in the channel wrap, shows up in the codes and in the seq_done position, especially for lengths 0, 8 or more, and 1, and for a base channel near 7. The FIFO cases chain sequences and then abort them. They catch an index that resets when it should run on, that survives an abort, or that a trigger clears. Trigger-while-busy and power-low cases catch a design that restarts or converts when it should ignore the request.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    // Position of the engine inside one conversion
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMP_A = 2'd1,
        PH_SAMP_B = 2'd2,
        PH_TRIAL  = 2'd3
    } adc_phase_e;

    // Decoded conversions per sequence: 0 or >= num_ch means num_ch
    function automatic int unsigned seq_len(input int unsigned code, input int unsigned num_ch);
        if (code == 0 || code >= num_ch) return num_ch;
        return code;
    endfunction

endpackage

// File: rtl/adc_clkdiv.sv
`timescale 1ns/1ps
module adc_clkdiv #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    localparam int CNT_W = PRS_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             st_d, st_q;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    always_comb begin
        last_cnt = {prs, 1'b1};               // 2*(prs+1)-1
        wrap     = (st_q.cnt == last_cnt);
        tick     = run && !clr && wrap;
        st_d     = st_q;
        if (!run || clr)  st_d.cnt = '0;
        else if (wrap)    st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: the conversion clock is never faster than half the bus clock
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_sar_engine.sv
`timescale 1ns/1ps
module adc_sar_engine
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int LOW_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                kill,
    input  logic                tick,
    input  logic                cont,
    input  logic [1:0]          smp_sel,
    input  logic                res8,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] code_now,
    output logic                conv_end,
    output logic                run
);
    localparam int STEP_W = $clog2(2 + 16 + RES_BITS + 1);

    typedef struct packed {
        logic                run;
        logic [STEP_W-1:0]   step;
        logic [RES_BITS-1:0] sar;
    } eng_t;

    eng_t                st_d, st_q;
    logic [STEP_W-1:0]   trial0, last_step, offs, bitpos;
    logic [RES_BITS-1:0] onehot;
    logic                in_trial;
    adc_phase_e          phase;

    always_comb begin
        trial0    = STEP_W'(2) + (STEP_W'(2) << smp_sel);
        last_step = trial0 + (res8 ? STEP_W'(LOW_BITS) : STEP_W'(RES_BITS)) - STEP_W'(1);
        in_trial  = st_q.run && (st_q.step >= trial0);
        offs      = st_q.step - trial0;
        bitpos    = STEP_W'(RES_BITS - 1) - offs;
        onehot    = RES_BITS'(1) << bitpos;
        code_now  = (st_q.sar & ~onehot) | (cmp_in ? onehot : '0);
        dac_code  = in_trial ? (st_q.sar | onehot) : '0;
        conv_end  = st_q.run && tick && (st_q.step == last_step);

        if (!st_q.run)                 phase = PH_IDLE;
        else if (st_q.step < STEP_W'(2)) phase = PH_SAMP_A;
        else if (!in_trial)            phase = PH_SAMP_B;
        else                           phase = PH_TRIAL;

        st_d = st_q;
        if (go) begin
            st_d.run  = 1'b1;
            st_d.step = '0;
            st_d.sar  = '0;
        end else if (kill) begin
            st_d.run  = 1'b0;
            st_d.step = '0;
            st_d.sar  = '0;
        end else if (st_q.run && tick) begin
            if (conv_end) begin
                st_d.step = '0;
                st_d.sar  = '0;
                st_d.run  = cont;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
                if (in_trial) st_d.sar = code_now;
            end
        end
    end

    assign run = st_q.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: every conversion begins in the first sample part with a clean register
    a_r2_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMP_A) |-> (st_q.sar == '0));
    // R2: the second sample part is only ever left for the trials, never back to the first part
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAMP_B && !go && !kill) |=> (phase != PH_SAMP_A));
    // R9: the first trial drives the MSB
    a_r9_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_trial && st_q.step == trial0) |-> dac_code[RES_BITS-1]);
    // R8: short conversions never touch the low bits
    a_r8_low_bits_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (res8 && in_trial) |-> (dac_code[RES_BITS-LOW_BITS-1:0] == '0));

endmodule

// File: rtl/adc_seq_sched.sv
`timescale 1ns/1ps
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SEQ_W    = 4,
    parameter int RES_BITS = 10,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_en,
    input  logic                start,
    input  logic                trig,
    input  logic                cfg_wr,
    input  logic [SEQ_W-1:0]    len_code,
    input  logic                multi,
    input  logic                scan,
    input  logic                fifo,
    input  logic [CH_W-1:0]     chan_sel,
    input  logic                conv_end,
    input  logic [RES_BITS-1:0] code_now,
    output logic                go,
    output logic                kill,
    output logic                cont,
    output logic                active,
    output logic [CH_W-1:0]     mux_sel,
    output logic                res_vld,
    output logic [CH_W-1:0]     res_idx,
    output logic [RES_BITS-1:0] res_code,
    output logic                seq_done
);
    typedef struct packed {
        logic                active;
        logic [CH_W-1:0]     conv;
        logic [CH_W-1:0]     idx;
        logic [CH_W-1:0]     mux;
        logic                vld;
        logic [CH_W-1:0]     ridx;
        logic [RES_BITS-1:0] rcode;
        logic                done;
    } seq_t;

    seq_t          st_d, st_q;
    logic [CH_W:0] len;
    logic          last;

    always_comb begin
        len  = (CH_W+1)'(seq_len(int'(len_code), NUM_CH));
        last = ({1'b0, st_q.conv} == (len - (CH_W+1)'(1)));
        go   = pwr_en && (start || (trig && !st_q.active));
        kill = !pwr_en || cfg_wr;
        cont = !last || scan;

        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.done = 1'b0;
        if (go) begin
            st_d.active = 1'b1;
            st_d.conv   = '0;
            st_d.mux    = chan_sel;
            if (start) st_d.idx = '0;
        end else if (kill) begin
            st_d.active = 1'b0;
            st_d.conv   = '0;
            st_d.idx    = '0;
        end else if (conv_end) begin
            st_d.vld   = 1'b1;
            st_d.ridx  = st_q.idx;
            st_d.rcode = code_now;
            st_d.done  = last;
            st_d.idx   = (last && !fifo) ? '0 : st_q.idx + CH_W'(1);
            if (last) begin
                st_d.conv   = '0;
                st_d.mux    = chan_sel;
                st_d.active = scan;
            end else begin
                st_d.conv = st_q.conv + CH_W'(1);
                if (multi) st_d.mux = st_q.mux + CH_W'(1);
            end
        end
    end

    assign active   = st_q.active;
    assign mux_sel  = st_q.mux;
    assign res_vld  = st_q.vld;
    assign res_idx  = st_q.ridx;
    assign res_code = st_q.rcode;
    assign seq_done = st_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: strobes are single-cycle pulses
    a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);
    // R3: sequence end is reported together with a result
    a_r3_done_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> res_vld);
    // R11: power low leaves the controller idle
    a_r11_power_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !active);
    // R4: a single-mode sequence ends idle
    a_r4_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !$past(scan) && !$past(go)) |-> !active);
    // R6: without FIFO mode the slot index restarts after a sequence
    a_r6_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !$past(fifo) && !$past(go)) |-> (st_q.idx == '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 10,
    parameter int LOW_BITS = 8,
    parameter int PRS_W    = 5,
    parameter int SEQ_W    = 4,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_en,
    input  logic                start,
    input  logic                trig_start,
    input  logic                cfg_wr,
    input  logic [PRS_W-1:0]    prs,
    input  logic [1:0]          smp_sel,
    input  logic [SEQ_W-1:0]    len_code,
    input  logic                res8,
    input  logic                multi,
    input  logic                scan,
    input  logic                fifo,
    input  logic [CH_W-1:0]     chan_sel,
    input  logic                cmp_in,
    output logic [CH_W-1:0]     mux_sel,
    output logic [RES_BITS-1:0] dac_code,
    output logic                res_vld,
    output logic [CH_W-1:0]     res_idx,
    output logic [RES_BITS-1:0] res_code,
    output logic                seq_done,
    output logic                busy
);
    logic                go, kill, cont, active, tick, conv_end, eng_run;
    logic [RES_BITS-1:0] code_now;

    adc_clkdiv #(.PRS_W(PRS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .clr   (go || kill),
        .prs   (prs),
        .tick  (tick)
    );

    adc_sar_engine #(.RES_BITS(RES_BITS), .LOW_BITS(LOW_BITS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .kill     (kill),
        .tick     (tick),
        .cont     (cont),
        .smp_sel  (smp_sel),
        .res8     (res8),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .code_now (code_now),
        .conv_end (conv_end),
        .run      (eng_run)
    );

    adc_seq_sched #(.NUM_CH(NUM_CH), .SEQ_W(SEQ_W), .RES_BITS(RES_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (pwr_en),
        .start    (start),
        .trig     (trig_start),
        .cfg_wr   (cfg_wr),
        .len_code (len_code),
        .multi    (multi),
        .scan     (scan),
        .fifo     (fifo),
        .chan_sel (chan_sel),
        .conv_end (conv_end),
        .code_now (code_now),
        .go       (go),
        .kill     (kill),
        .cont     (cont),
        .active   (active),
        .mux_sel  (mux_sel),
        .res_vld  (res_vld),
        .res_idx  (res_idx),
        .res_code (res_code),
        .seq_done (seq_done)
    );

    assign busy = active;

    // R4: engine and sequencer agree on whether a sequence is running
    a_r4_engine_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run == active);
    // R7: an abort request leaves no sequence running
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !start) |=> !busy);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b1, start = 1'b0, trig_start = 1'b0, cfg_wr = 1'b0;
    logic [4:0] prs = 5'd5;
    logic [1:0] smp_sel = 2'd0;
    logic [3:0] len_code = 4'd4;
    logic       res8 = 1'b0, multi = 1'b0, scan = 1'b0, fifo = 1'b0;
    logic [2:0] chan_sel = 3'd0;
    logic       cmp_in;
    logic [2:0] mux_sel, res_idx;
    logic [9:0] dac_code, res_code;
    logic       res_vld, seq_done, busy;

    logic [9:0] analog [8];
    int         cyc = 0;
    int         n_chk = 0, n_err = 0;
    bit         finished = 1'b0;
    int         n_ev = 0;
    int         ev_cyc [64];
    int         ev_idx [64];
    int         ev_code[64];
    int         ev_done[64];

    always #5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .start(start),
        .trig_start(trig_start), .cfg_wr(cfg_wr), .prs(prs), .smp_sel(smp_sel),
        .len_code(len_code), .res8(res8), .multi(multi), .scan(scan), .fifo(fifo),
        .chan_sel(chan_sel), .cmp_in(cmp_in), .mux_sel(mux_sel), .dac_code(dac_code),
        .res_vld(res_vld), .res_idx(res_idx), .res_code(res_code),
        .seq_done(seq_done), .busy(busy)
    );

    // ideal comparator: high when the selected input is at least the DAC code
    assign cmp_in = (analog[mux_sel] >= dac_code);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            if (n_ev < 64) begin
                ev_cyc[n_ev]  = cyc;
                ev_idx[n_ev]  = int'(res_idx);
                ev_code[n_ev] = int'(res_code);
                ev_done[n_ev] = int'(seq_done);
            end
            n_ev = n_ev + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        return (code == 0 || code >= 8) ? 8 : code;
    endfunction

    function automatic int conv_clocks(input int smp, input int r8);
        return 2 + (2 << smp) + (r8 != 0 ? 8 : 10);
    endfunction

    task automatic run_case(input int p, input int smp, input int lc, input int r8,
                            input int mu, input int sc, input int ff, input int ch,
                            input int use_trig, input int idx0, input int nconv, input int poke);
        int d, t, l, s, g;
        d = 2 * (p + 1);
        t = conv_clocks(smp, r8);
        l = len_of(lc);
        @(negedge clk);
        prs = 5'(p); smp_sel = 2'(smp); len_code = 4'(lc); res8 = r8[0];
        multi = mu[0]; scan = sc[0]; fifo = ff[0]; chan_sel = 3'(ch);
        if (use_trig != 0) trig_start = 1'b1; else start = 1'b1;
        n_ev = 0;
        @(negedge clk);
        s = cyc;
        start = 1'b0; trig_start = 1'b0;
        if (poke != 0) begin
            repeat (3) @(negedge clk);
            trig_start = 1'b1;
            @(negedge clk);
            trig_start = 1'b0;
        end
        g = 0;
        while (n_ev < nconv && g < d * t * (nconv + 2)) begin
            @(negedge clk);
            g++;
        end
        if (sc != 0) begin
            cfg_wr = 1'b1;
            @(negedge clk);
            cfg_wr = 1'b0;
            repeat (2 * d * t) @(negedge clk);
            chk(n_ev == nconv, "R7", "strobes after abort", n_ev, nconv);
            chk(busy == 1'b0, "R7", "busy after abort", int'(busy), 0);
        end else begin
            repeat (d * t + 4) @(negedge clk);
            chk(n_ev == nconv, "R3 R4", "strobes in single sequence", n_ev, nconv);
            chk(busy == 1'b0, "R4", "busy after single sequence", int'(busy), 0);
        end
        for (int m = 0; m < nconv && m < 64; m++) begin
            int k, c, ei, ec, ecy, ed;
            k   = m % l;
            c   = (mu != 0) ? (ch + k) % 8 : ch;
            ei  = (ff != 0) ? (idx0 + m) % 8 : k;
            ec  = int'(analog[c]) & ((r8 != 0) ? 32'h3FC : 32'h3FF);
            ecy = s + d * t * (m + 1);
            ed  = (k == l - 1) ? 1 : 0;
            chk(ev_cyc[m] == ecy, "R1 R2", "strobe cycle", ev_cyc[m], ecy);
            chk(ev_idx[m] == ei, "R6", "result slot", ev_idx[m], ei);
            chk(ev_code[m] == ec, (r8 != 0) ? "R5 R8" : "R5 R9", "result code", ev_code[m], ec);
            chk(ev_done[m] == ed, "R3 R10", "sequence done flag", ev_done[m], ed);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7781));
        for (int i = 0; i < 8; i++) analog[i] = 10'(37 + i * 131);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
        chk(res_vld == 1'b0, "R10", "reset strobe", int'(res_vld), 0);
        chk(seq_done == 1'b0, "R10", "reset done", int'(seq_done), 0);
        chk(dac_code == 10'd0, "R10", "reset dac", int'(dac_code), 0);

        // divide-by-12, multi-channel wrap 6,7,0,1
        run_case(5, 0, 4, 0, 1, 0, 0, 6, 0, 0, 4, 0);
        // 8-bit, longest sample, length code 0
        run_case(1, 3, 0, 1, 1, 0, 0, 2, 0, 0, 8, 0);
        // single channel, length code with top bit set
        run_case(0, 1, 10, 0, 0, 0, 0, 5, 0, 0, 8, 0);
        // continuous with FIFO: slot runs on, then abort
        run_case(0, 0, 3, 0, 1, 1, 1, 1, 0, 0, 7, 0);
        // continuous without FIFO: slot restarts each sequence
        run_case(0, 0, 3, 0, 1, 1, 0, 1, 0, 0, 7, 0);
        // FIFO single sequence leaves slot at 3
        run_case(0, 2, 3, 0, 1, 0, 1, 4, 0, 0, 3, 0);
        // trigger start keeps slot; trigger while busy is ignored (R12)
        run_case(0, 2, 3, 0, 1, 0, 1, 4, 1, 3, 3, 1);
        // after an abort, start clears slot even with FIFO (R7)
        run_case(0, 0, 2, 0, 0, 1, 1, 0, 0, 0, 3, 0);
        run_case(0, 0, 2, 0, 0, 0, 1, 3, 0, 0, 2, 0);
        // length 1
        run_case(2, 0, 1, 1, 0, 0, 0, 7, 0, 0, 1, 0);

        // R11: power low ignores start
        @(negedge clk);
        pwr_en = 1'b0; prs = 5'd0; smp_sel = 2'd0; len_code = 4'd2; scan = 1'b0;
        n_ev = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        chk(n_ev == 0, "R11", "strobes while powered down", n_ev, 0);
        chk(busy == 1'b0, "R11", "busy while powered down", int'(busy), 0);
        // R11: power drop aborts a running sequence
        pwr_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        pwr_en = 1'b0;
        repeat (300) @(negedge clk);
        chk(n_ev == 0, "R11", "strobes after power drop", n_ev, 0);
        chk(busy == 1'b0, "R11", "busy after power drop", int'(busy), 0);
        pwr_en = 1'b1;

        // constrained random single sequences
        for (int r = 0; r < 8; r++) begin
            int p, sm, lc, r8, mu, ch;
            for (int i = 0; i < 8; i++) analog[i] = 10'($urandom % 1024);
            p  = int'($urandom % 4);
            sm = int'($urandom % 4);
            lc = int'($urandom % 16);
            r8 = int'($urandom % 2);
            mu = int'($urandom % 2);
            ch = int'($urandom % 8);
            run_case(p, sm, lc, r8, mu, 0, 0, ch, 0, 0, len_of(lc), 0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule